// File: doc/BRIEF.md
# Serial ADC Power-Mode Host Controller

This block is the host side of a four-wire serial link to a 12-bit, eight-input converter that can power itself down between conversions. User logic asks for a conversion with a channel number and a power-mode code. The controller runs a 16-clock frame with chip select held low. It shifts out an 8-bit control word and shifts in the 16-bit reply, which is four zero bits followed by the 12-bit result. It then returns the result with its channel tag for one cycle.

The controller keeps its own record of the converter's power state, based on the mode code of each completed frame. A converter left in standby wakes early enough that the next frame is valid as it is. A converter left in shutdown needs time before it samples, and a parameter selects how that is handled. The delay variant stretches the gap between chip select falling and the first serial clock edge by a programmed number of system clocks. The repeat variant first runs a throw-away frame that writes the always-on mode, then runs the requested frame. The result of the throw-away frame is never reported.

Top module: `adc_pm_host`

## Requirements
- R1: A frame holds adc_cs_n low for exactly 16 adc_sclk periods. adc_sclk idles high whenever adc_cs_n is high. adc_mosi changes only on the cycle adc_sclk falls, and adc_miso is sampled when adc_sclk rises.
- R2: The control word is sent MSB first on the first 8 falling edges. Bits 7:6 are 0, bits 5:3 carry the channel, bit 2 is 0 and bits 1:0 carry the power-mode code. The last 8 bits of the frame are 0.
- R3: result_data is the last 12 bits received in the frame, MSB first, and the four leading bits are dropped. result_valid is high for exactly one cycle per accepted request, with result_chan equal to the requested channel.
- R4: The power-mode codes are 00 for always on, 11 for standby after each conversion, and 10 for shutdown after each conversion. The tracker takes 00 as powered, 11 as standby, and both 10 and 01 as shutdown. After reset it assumes powered.
- R5: When the tracker says powered or standby, the first adc_sclk fall comes HALF_DIV clocks after adc_cs_n falls, so the second rise comes 4*HALF_DIV clocks after it.
- R6: With REPEAT_WAKE = 0 and the tracker in shutdown, the first adc_sclk fall comes WAKE_CYCLES+1 clocks after adc_cs_n falls, and that frame's result is reported.
- R7: With REPEAT_WAKE = 1 and the tracker in shutdown, the controller first runs a frame with the requested channel and mode 00 and discards its result. It then runs the requested frame with short lead timing and reports only that result.
- R8: req_ready is high only while no frame sequence is in progress. A req_valid seen while req_ready is low is ignored, so it starts no frame and changes no tracked state.
- R9: Asserting rst_n low at once forces adc_cs_n and adc_sclk high and result_valid low, and an aborted frame reports nothing. After release, req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Conversion request strobe |
| req_chan | input | 3 | Requested input channel |
| req_mode | input | 2 | Power-mode code to write with this conversion |
| req_ready | output | 1 | Controller idle and able to take a request |
| result_valid | output | 1 | One-cycle result strobe |
| result_data | output | 12 | Conversion result |
| result_chan | output | 3 | Channel tag of the result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_mosi | output | 1 | Serial data to the converter |
| adc_miso | input | 1 | Serial data from the converter |

## Verification
The bench runs both wake variants side by side against a converter model. The model scores a conversion as invalid if it is sampled too soon after shutdown, and it records every control word and lead time. The sequence passes through every transition between power states, and it includes mode 01 followed by 00, so a tracker that treated 01 as powered would give a short lead and be caught by an invalid conversion. A design that reported the throw-away frame, or skipped it, shows up as the wrong data or the wrong frame count. A design that accepted a request while busy, or did not clear its tracked state on a reset mid-frame, shows up as an extra frame, the wrong control word or a wrong lead time.

// File: rtl/adc_pm_pkg.sv
package adc_pm_pkg;

  localparam int CHAN_W     = 3;
  localparam int MODE_W     = 2;
  localparam int CTRL_W     = 8;
  localparam int DATA_W     = 12;
  localparam int FRAME_BITS = 16;

  localparam logic [MODE_W-1:0] MODE_ON   = 2'b00;
  localparam logic [MODE_W-1:0] MODE_STBY = 2'b11;

  typedef enum logic [1:0] {PWR_ON, PWR_STBY, PWR_SHUT} pwr_e;

  typedef enum logic [2:0] {F_IDLE, F_LEAD, F_LOW, F_HIGH, F_TAIL} frm_e;

  typedef enum logic [1:0] {Q_IDLE, Q_DISC, Q_MAIN} seq_e;

  function automatic logic [CTRL_W-1:0] ctrl_word(input logic [CHAN_W-1:0] ch,
                                                  input logic [MODE_W-1:0] md);
    return {2'b00, ch, 1'b0, md};
  endfunction

  function automatic pwr_e pwr_after(input logic [MODE_W-1:0] md);
    case (md)
      MODE_ON:   return PWR_ON;
      MODE_STBY: return PWR_STBY;
      default:   return PWR_SHUT;
    endcase
  endfunction

endpackage

// File: rtl/adc_pm_frame.sv
module adc_pm_frame
  import adc_pm_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int WAKE_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_long,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);

  localparam int MAXC  = (WAKE_CYCLES > HALF_DIV) ? WAKE_CYCLES : HALF_DIV;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_CYCLES);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  frm_e                  st_q, st_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  cs_q, cs_d, sclk_q, sclk_d, mosi_q, mosi_d, done_q, done_d;
  logic                  cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    cs_d   = cs_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    done_d = 1'b0;
    case (st_q)
      F_IDLE: if (start) begin
        st_d  = F_LEAD;
        cs_d  = 1'b0;
        tx_d  = {ctrl, {(FRAME_BITS-CTRL_W){1'b0}}};
        cnt_d = start_long ? WAKE_LD : HALF_LD;
        bit_d = '0;
      end
      F_LEAD: if (cnt_zero) begin
        st_d   = F_LOW;
        sclk_d = 1'b0;
        mosi_d = tx_q[FRAME_BITS-1];
        tx_d   = tx_q << 1;
        cnt_d  = HALF_LD;
      end else cnt_d = cnt_q - 1'b1;
      F_LOW: if (cnt_zero) begin
        st_d   = F_HIGH;
        sclk_d = 1'b1;
        rx_d   = {rx_q[DATA_W-2:0], miso};
        cnt_d  = HALF_LD;
      end else cnt_d = cnt_q - 1'b1;
      F_HIGH: if (cnt_zero) begin
        cnt_d = HALF_LD;
        if (bit_q == LAST_BIT) begin
          st_d = F_TAIL;
        end else begin
          st_d   = F_LOW;
          bit_d  = bit_q + 1'b1;
          sclk_d = 1'b0;
          mosi_d = tx_q[FRAME_BITS-1];
          tx_d   = tx_q << 1;
        end
      end else cnt_d = cnt_q - 1'b1;
      F_TAIL: if (cnt_zero) begin
        st_d   = F_IDLE;
        cs_d   = 1'b1;
        mosi_d = 1'b0;
        done_d = 1'b1;
      end else cnt_d = cnt_q - 1'b1;
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
    end
  end

  assign done    = done_q;
  assign rx_data = rx_q;
  assign cs_n    = cs_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

endmodule

// File: rtl/adc_pm_seq.sv
module adc_pm_seq
  import adc_pm_pkg::*;
#(
  parameter bit REPEAT_WAKE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [MODE_W-1:0] req_mode,
  output logic              req_ready,
  input  logic              frm_done,
  input  logic [DATA_W-1:0] frm_rx,
  output logic              start,
  output logic              start_long,
  output logic [CTRL_W-1:0] start_ctrl,
  output logic              frame_long,
  output logic              result_valid,
  output logic [DATA_W-1:0] result_data,
  output logic [CHAN_W-1:0] result_chan
);

  seq_e              st_q, st_d;
  pwr_e              pwr_q, pwr_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              long_q, long_d;
  logic              val_q, val_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              shut_wait;
  logic              shut_repeat;

  generate
    if (REPEAT_WAKE) begin : g_repeat
      assign shut_wait   = 1'b0;
      assign shut_repeat = (pwr_q == PWR_SHUT);
    end else begin : g_delay
      assign shut_wait   = (pwr_q == PWR_SHUT);
      assign shut_repeat = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d       = st_q;
    pwr_d      = pwr_q;
    chan_d     = chan_q;
    mode_d     = mode_q;
    long_d     = long_q;
    val_d      = 1'b0;
    data_d     = data_q;
    start      = 1'b0;
    start_long = 1'b0;
    start_ctrl = ctrl_word(chan_q, mode_q);
    case (st_q)
      Q_IDLE: if (req_valid) begin
        chan_d     = req_chan;
        mode_d     = req_mode;
        start      = 1'b1;
        start_long = shut_wait;
        long_d     = shut_wait;
        start_ctrl = ctrl_word(req_chan, shut_repeat ? MODE_ON : req_mode);
        st_d       = shut_repeat ? Q_DISC : Q_MAIN;
      end
      Q_DISC: if (frm_done) begin
        pwr_d  = PWR_ON;
        start  = 1'b1;
        long_d = 1'b0;
        st_d   = Q_MAIN;
      end
      Q_MAIN: if (frm_done) begin
        val_d  = 1'b1;
        data_d = frm_rx;
        pwr_d  = pwr_after(mode_q);
        long_d = 1'b0;
        st_d   = Q_IDLE;
      end
      default: st_d = Q_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= Q_IDLE;
      pwr_q  <= PWR_ON;
      chan_q <= '0;
      mode_q <= '0;
      long_q <= 1'b0;
      val_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      pwr_q  <= pwr_d;
      chan_q <= chan_d;
      mode_q <= mode_d;
      long_q <= long_d;
      val_q  <= val_d;
      data_q <= data_d;
    end
  end

  assign req_ready    = (st_q == Q_IDLE);
  assign frame_long   = long_q;
  assign result_valid = val_q;
  assign result_data  = data_q;
  assign result_chan  = chan_q;

endmodule

// File: rtl/adc_pm_host.sv
module adc_pm_host
  import adc_pm_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int WAKE_CYCLES = 500,
  parameter bit REPEAT_WAKE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_chan,
  input  logic [1:0]  req_mode,
  output logic        req_ready,
  output logic        result_valid,
  output logic [11:0] result_data,
  output logic [2:0]  result_chan,
  output logic        adc_cs_n,
  output logic        adc_sclk,
  output logic        adc_mosi,
  input  logic        adc_miso
);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              frm_done;
  logic [DATA_W-1:0] frm_rx;
  logic              start, start_long, frame_long;
  logic [CTRL_W-1:0] start_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  adc_pm_seq #(.REPEAT_WAKE(REPEAT_WAKE)) u_seq (
    .clk(clk), .rst_n(core_rst_n),
    .req_valid(req_valid), .req_chan(req_chan), .req_mode(req_mode),
    .req_ready(req_ready),
    .frm_done(frm_done), .frm_rx(frm_rx),
    .start(start), .start_long(start_long), .start_ctrl(start_ctrl),
    .frame_long(frame_long),
    .result_valid(result_valid), .result_data(result_data), .result_chan(result_chan)
  );

  adc_pm_frame #(.HALF_DIV(HALF_DIV), .WAKE_CYCLES(WAKE_CYCLES)) u_frame (
    .clk(clk), .rst_n(core_rst_n),
    .start(start), .start_long(start_long), .ctrl(start_ctrl),
    .done(frm_done), .rx_data(frm_rx),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .mosi(adc_mosi), .miso(adc_miso)
  );

endmodule

// File: rtl/adc_pm_host_chk.sv
module adc_pm_host_chk #(
  parameter int WAKE_CYCLES = 500
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic req_ready,
  input logic result_valid,
  input logic frame_long
);

  logic [31:0] gap_cnt;
  logic [4:0]  rises;
  logic        sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt   <= '0;
      rises     <= '0;
      sclk_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk;
      if (cs_n) begin
        gap_cnt <= '0;
        rises   <= '0;
      end else begin
        if (gap_cnt != 32'hFFFF_FFFF) gap_cnt <= gap_cnt + 1'b1;
        if (sclk && !sclk_prev) rises <= rises + 1'b1;
      end
    end
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);

  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$past(cs_n) && !$fell(sclk)) |-> $stable(mosi));

  // R1
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rises == 5'd16));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R6
  wake_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && frame_long) |-> (gap_cnt >= 32'(WAKE_CYCLES)));

endmodule

bind adc_pm_host adc_pm_host_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .sclk(adc_sclk), .mosi(adc_mosi),
  .req_ready(req_ready), .result_valid(result_valid), .frame_long(frame_long)
);

// File: tb/adc_pm_host_tb_top.sv
module adc_model #(
  parameter int WAKE = 40,
  parameter int PER  = 10
) (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        mosi,
  output logic        miso,
  output int          frames,
  output logic [7:0]  last_ctrl,
  output logic [7:0]  prev_ctrl,
  output logic [11:0] last_data,
  output logic        last_ok,
  output int          last_rise2
);
  int          pstate = 0;
  int          rises = 0;
  int          falls = 0;
  int          r2 = 0;
  time         tfall = 0;
  logic [7:0]  sh = '0;
  logic [11:0] cur = '0;
  logic        ok_cur = 1'b1;

  initial begin
    miso = 1'b0; frames = 0; last_ctrl = '0; prev_ctrl = '0;
    last_data = '0; last_ok = 1'b0; last_rise2 = 0;
  end

  always @(negedge cs_n) begin
    tfall = $time; rises = 0; falls = 0; ok_cur = 1'b1;
    cur = 12'((frames + 1) * 419 + 92);
    miso = 1'b0;
  end

  always @(negedge sclk) if (!cs_n) begin
    falls = falls + 1;
    if (falls >= 5 && falls <= 16) miso = cur[16 - falls];
    else miso = 1'b0;
  end

  always @(posedge sclk) if (!cs_n) begin
    rises = rises + 1;
    if (rises <= 8) sh = {sh[6:0], mosi};
    if (rises == 2) begin
      r2 = int'(($time - tfall) / PER);
      if (pstate == 2 && r2 < WAKE) ok_cur = 1'b0;
    end
  end

  always @(posedge cs_n) if (rises == 16) begin
    frames = frames + 1;
    prev_ctrl = last_ctrl;
    last_ctrl = sh;
    last_data = cur;
    last_ok = ok_cur;
    last_rise2 = r2;
    pstate = (sh[1:0] == 2'b00) ? 0 : (sh[1:0] == 2'b11) ? 1 : 2;
  end
endmodule

module adc_pm_host_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int WAKE = 40;
  localparam int SHORT_R2 = 4 * HALF;
  localparam int LONG_R2 = WAKE + 1 + 3 * HALF;
  localparam int NV = 9;
  // chan, mode, frames(delay), frames(repeat), long lead(delay)
  localparam int VEC [NV][5] = '{
    '{3, 0, 1, 1, 0}, '{5, 2, 1, 1, 0}, '{1, 0, 1, 2, 1},
    '{7, 3, 1, 1, 0}, '{2, 3, 1, 1, 0}, '{0, 2, 1, 1, 0},
    '{6, 2, 1, 2, 1}, '{4, 1, 1, 2, 1}, '{5, 0, 1, 2, 1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_chan = '0;
  logic [1:0] req_mode = '0;

  logic rdy_a, val_a, cs_a, sck_a, mosi_a, miso_a;
  logic rdy_b, val_b, cs_b, sck_b, mosi_b, miso_b;
  logic [11:0] dat_a, dat_b, ld_a, ld_b;
  logic [2:0] ch_a, ch_b;
  logic [7:0] lc_a, lc_b, pc_a, pc_b;
  logic ok_a, ok_b;
  int fr_a, fr_b, r2_a, r2_b;
  int pulses_a = 0, pulses_b = 0;
  logic [11:0] cap_da = '0, cap_db = '0;
  logic [2:0] cap_ca = '0, cap_cb = '0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_pm_host #(.HALF_DIV(HALF), .WAKE_CYCLES(WAKE), .REPEAT_WAKE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_mode(req_mode), .req_ready(rdy_a), .result_valid(val_a),
    .result_data(dat_a), .result_chan(ch_a), .adc_cs_n(cs_a), .adc_sclk(sck_a),
    .adc_mosi(mosi_a), .adc_miso(miso_a));

  adc_pm_host #(.HALF_DIV(HALF), .WAKE_CYCLES(WAKE), .REPEAT_WAKE(1'b1)) dut_r_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_mode(req_mode), .req_ready(rdy_b), .result_valid(val_b),
    .result_data(dat_b), .result_chan(ch_b), .adc_cs_n(cs_b), .adc_sclk(sck_b),
    .adc_mosi(mosi_b), .adc_miso(miso_b));

  adc_model #(.WAKE(WAKE), .PER(CLK_PERIOD)) mdl_a (
    .cs_n(cs_a), .sclk(sck_a), .mosi(mosi_a), .miso(miso_a), .frames(fr_a),
    .last_ctrl(lc_a), .prev_ctrl(pc_a), .last_data(ld_a), .last_ok(ok_a), .last_rise2(r2_a));

  adc_model #(.WAKE(WAKE), .PER(CLK_PERIOD)) mdl_b (
    .cs_n(cs_b), .sclk(sck_b), .mosi(mosi_b), .miso(miso_b), .frames(fr_b),
    .last_ctrl(lc_b), .prev_ctrl(pc_b), .last_data(ld_b), .last_ok(ok_b), .last_rise2(r2_b));

  always @(posedge clk) begin
    if (val_a) begin pulses_a = pulses_a + 1; cap_da = dat_a; cap_ca = ch_a; end
    if (val_b) begin pulses_b = pulses_b + 1; cap_db = dat_b; cap_cb = ch_b; end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input int ch, input int md);
    return {2'b00, 3'(ch), 1'b0, 2'(md)};
  endfunction

  task automatic issue(input int ch, input int md);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'(ch); req_mode = 2'(md);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_both(input int pa, input int pb);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pulses_a > pa && pulses_b > pb) break;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic run_vec(input int ch, input int md, input int fd, input int fr, input int lg);
    int fa0, fb0, pa0, pb0;
    fa0 = fr_a; fb0 = fr_b; pa0 = pulses_a; pb0 = pulses_b;
    issue(ch, md);
    wait_both(pa0, pb0);
    chk(pulses_a - pa0 == 1, "R3 delay one result pulse", pulses_a - pa0, 1);
    chk(pulses_b - pb0 == 1, "R3 repeat one result pulse", pulses_b - pb0, 1);
    chk(cap_da == ld_a, "R3 delay result data", cap_da, ld_a);
    chk(cap_db == ld_b, "R3 repeat result data", cap_db, ld_b);
    chk(cap_ca == 3'(ch) && cap_cb == 3'(ch), "R3 result channel tag", cap_ca, ch);
    chk(lc_a == cw(ch, md), "R2 delay control word", lc_a, cw(ch, md));
    chk(lc_b == cw(ch, md), "R2 repeat control word", lc_b, cw(ch, md));
    chk(ok_a, "R6 delay reported conversion valid", ok_a, 1);
    chk(ok_b, "R7 repeat reported conversion valid", ok_b, 1);
    chk(fr_a - fa0 == fd, "R6 delay frame count", fr_a - fa0, fd);
    chk(fr_b - fb0 == fr, "R7 repeat frame count", fr_b - fb0, fr);
    if (fr == 2)
      chk(pc_b == cw(ch, 0), "R7 discard frame writes mode 00", pc_b, cw(ch, 0));
    chk(r2_a == (lg ? LONG_R2 : SHORT_R2), "R5 R6 delay lead timing", r2_a,
        lg ? LONG_R2 : SHORT_R2);
    chk(r2_b == SHORT_R2, "R5 repeat lead timing", r2_b, SHORT_R2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(cs_a && cs_b && sck_a && sck_b, "R9 idle lines during reset", {cs_a, sck_a}, 3);
    chk(!val_a && !val_b, "R9 no result during reset", val_a, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy_a && rdy_b, "R9 ready after reset", rdy_a, 1);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);

    // R8 request while busy is ignored
    begin
      int fa0, pa0, pb0;
      fa0 = fr_a; pa0 = pulses_a; pb0 = pulses_b;
      issue(3, 0);
      repeat (3) @(negedge clk);
      chk(!rdy_a && !rdy_b, "R8 ready low while busy", rdy_a, 0);
      issue(6, 2);
      wait_both(pa0, pb0);
      repeat (100) @(negedge clk);
      chk(pulses_a - pa0 == 1 && pulses_b - pb0 == 1, "R8 busy request gives no result",
          pulses_a - pa0, 1);
      chk(fr_a - fa0 == 1, "R8 busy request starts no frame", fr_a - fa0, 1);
      chk(lc_a == cw(3, 0) && cap_ca == 3'd3, "R8 busy request fields unused", lc_a, cw(3, 0));
    end
    // R8 R4 tracker unchanged by the ignored mode 10: next lead stays short
    run_vec(2, 0, 1, 1, 0);

    // R9 reset in the middle of a frame
    begin
      int pa0;
      pa0 = pulses_a;
      issue(1, 2);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(cs_a && sck_a && cs_b && sck_b, "R9 reset forces lines idle at once", {cs_a, sck_a}, 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(pulses_a == pa0 && rdy_a && rdy_b, "R9 aborted frame reports nothing", pulses_a - pa0, 0);
    end
    // R4 tracker assumes powered after reset
    run_vec(4, 0, 1, 1, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule